// File: doc/BRIEF.md
# Clocked Serial Receiver with Receive Queue

This block receives a clocked synchronous serial stream and stores the bytes in a small receive queue. A serial clock supplied from outside marks each data bit. Both the clock and the data are brought into the system clock domain through flop chains. The block looks for rising edges of the serial clock and shifts the bits in, least significant bit first. After every eighth bit, the finished byte is written into the queue.

Software or a DMA engine empties the queue through a four-register interface. The registers are a data port that pops a byte, a status register with a ready flag and an overrun flag, a register that holds the current fill count, and a control register. The control register sets receive enable, picks one of four trigger levels, and routes the ready request to the interrupt line or to the DMA request line. The ready flag stays set until it is cleared. Software clears it with a read-then-write handshake, and reads from a DMA engine clear it with no write. An overrun locks the receiver until software clears it.

Top module: `sync_serial_rx_fifo`

## Requirements
- R1: While receive is enabled, each rising edge of `ser_clk` samples `ser_dat`. The first sampled bit becomes bit 0 and the eighth becomes bit 7. Bytes come out of the data register (address 0) in the order they arrived.
- R2: The count register (address 2) returns the number of bytes held, from 0 to 16, in its low five bits. Each read of the data register that finds the queue non-empty lowers the count by one.
- R3: The ready flag (status bit 0) is set whenever the count is at or above the trigger level. Control bits [2:1] select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. Once set, the flag stays set after the count falls, until it is cleared.
- R4: Writing status bit 0 as 0 clears the ready flag only if the last status read before that write returned the flag as 1. Writing bit 0 as 1 has no effect on the flag. Either clear has effect only when the count is below the trigger level.
- R5: When control bit 3 is 0, `irq_o` equals the ready flag and `dma_req_o` is 0. When control bit 3 is 1, `dma_req_o` equals the ready flag and `irq_o` is 0.
- R6: When control bit 3 is 1, a read of the data register or the count register clears the ready flag with no write, provided the count after that read is below the trigger level.
- R7: If a byte completes while 16 bytes are already held, that byte is discarded, the count stays at 16, and the overrun flag (status bit 1) is set.
- R8: While the overrun flag is set, serial input is ignored. Writing status bit 1 as 0 clears the flag, and reception then restarts from bit 0.
- R9: When control bit 0 (receive enable) is 0, serial input is ignored and any partly received byte is dropped.
- R10: A data read from an empty queue returns the byte last popped and leaves the count at 0.
- R11: After reset, status, count and control all read 0, and `irq_o` and `dma_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | External serial clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, sampled on rising ser_clk |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 count, 3 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_o | output | 1 | Receive interrupt request |
| dma_req_o | output | 1 | Receive DMA request |

## Verification
The hardest state to reach from the ports is the overrun lock. Getting there takes a full queue followed by one more complete byte. After that, the bench must show that further serial traffic is ignored even while the queue has room, and that reception restarts cleanly once the flag is cleared. The stimulus first fills the queue with sixteen known bytes and sends a seventeenth. It then pops one byte, sends another that must be lost, clears the flag, and drains the queue against a model that holds only the accepted bytes. The sticky ready flag is handled the same way. Random rounds vary the trigger level, the burst length and the drain length. Directed steps then drop the count below the trigger level, so the order of status reads and writes decides whether the flag clears.

// File: rtl/srx_pkg.sv
// Shared definitions for the serial receive block: register addresses,
// status bit positions and the control register layout.
package srx_pkg;

    typedef enum logic [1:0] {
        RA_DATA  = 2'd0,
        RA_STAT  = 2'd1,
        RA_COUNT = 2'd2,
        RA_CTRL  = 2'd3
    } reg_addr_e;

    localparam int ST_RDY = 0;
    localparam int ST_OVR = 1;

    // Control register, bit 0 upward: enable, trigger select, request routing.
    typedef struct packed {
        logic       dma_sel;
        logic [1:0] trig_sel;
        logic       rx_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/srx_edge_sync.sv
// Brings the external serial clock and data into the system clock domain.
// Assumes each serial clock phase lasts at least two system clocks longer
// than the synchronizer depth. The data output is aligned with the
// rising-edge pulse, so sampling data on that pulse gives the bit that was
// stable at the serial rising edge.
module srx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic clk_rise,
    output logic dat_sync
);

    logic [STAGES:0]   clk_pipe;
    logic [STAGES-1:0] dat_pipe;

    // Shift both inputs through equal-depth chains; one extra clock stage for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_pipe <= '0;
            dat_pipe <= '0;
        end else begin
            clk_pipe <= {clk_pipe[STAGES-1:0], ser_clk};
            dat_pipe <= {dat_pipe[STAGES-2:0], ser_dat};
        end
    end

    assign clk_rise = clk_pipe[STAGES-1] & ~clk_pipe[STAGES];
    assign dat_sync = dat_pipe[STAGES-1];

endmodule

// File: rtl/srx_shifter.sv
// Assembles serial bits into bytes, least significant bit first.
// While hold is asserted the bit counter stays at zero, so any partial byte
// is dropped. byte_done pulses for one cycle in the cycle the last bit is
// sampled, and byte_out is valid in that same cycle.
module srx_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample,
    input  logic            bit_in,
    input  logic            hold,
    output logic            byte_done,
    output logic [BITS-1:0] byte_out
);

    localparam int BIT_W = $clog2(BITS);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(BITS - 1);

    logic [BITS-1:0]  sreg;
    logic [BIT_W-1:0] bit_cnt;

    // Next shift value: the new bit enters at the top and earlier bits move down.
    assign byte_out  = {bit_in, sreg[BITS-1:1]};
    assign byte_done = sample & ~hold & (bit_cnt == LAST);

    // Count and shift on each accepted sample; restart the count while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg    <= '0;
            bit_cnt <= '0;
        end else if (hold) begin
            bit_cnt <= '0;
        end else if (sample) begin
            sreg    <= byte_out;
            bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/srx_fifo.sv
// Receive queue with a fill count. A push into a full queue is refused and
// reported on overflow. A pop of an empty queue is ignored. count_next shows
// the count that will be registered at the next edge.
module srx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          pop,
    output logic [DATA_W-1:0]             head,
    output logic                          empty,
    output logic                          overflow,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic [$clog2(DEPTH+1)-1:0]    count_next
);

    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              full;
    logic              push_ok;
    logic              pop_ok;

    assign full     = (count == FULL_CNT);
    assign empty    = (count == '0);
    assign push_ok  = push & ~full;
    assign pop_ok   = pop & ~empty;
    assign overflow = push & full;
    assign head     = mem[rd_ptr];

    // Derive the next count from the accepted push and pop.
    always_comb begin
        count_next = count;
        if (push_ok && !pop_ok) count_next = count + 1'b1;
        if (pop_ok && !push_ok) count_next = count - 1'b1;
    end

    // Store the accepted byte; storage has no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Move the pointers, wrapping at DEPTH, and register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count <= count_next;
        end
    end

endmodule

// File: rtl/sync_serial_rx_fifo.sv
// Clocked synchronous serial receiver with a receive queue and a register
// port. The serial inputs are synchronized, shifted into bytes and queued.
// A sticky ready flag follows the programmed trigger level and drives either
// the interrupt or the DMA request. An overrun locks reception until it is
// cleared. Register reads return data one cycle after reg_rd. Assumes the
// serial clock is slow against clk, as srx_edge_sync requires.
module sync_serial_rx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TRIG_L0     = 1,
    parameter int TRIG_L1     = 4,
    parameter int TRIG_L2     = 8,
    parameter int TRIG_L3     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              dma_req_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    reg_addr_e          addr;
    ctrl_t              ctrl_q;
    logic               clk_rise;
    logic               dat_sync;
    logic               byte_done;
    logic [DATA_W-1:0]  byte_val;
    logic               rx_hold;
    logic               pop;
    logic [DATA_W-1:0]  head;
    logic               fifo_empty;
    logic               fifo_ovf;
    logic [CNT_W-1:0]   fifo_count;
    logic [CNT_W-1:0]   cnt_next;
    logic [CNT_W-1:0]   trig_lvl;
    logic               rdy_q;
    logic               ovr_q;
    logic               armed_q;
    logic               sw_clr;
    logic               dma_clr;
    logic               stat_wr;
    logic               stat_rd;
    logic [DATA_W-1:0]  last_q;
    logic [DATA_W-1:0]  rdata_q;

    assign addr    = reg_addr_e'(reg_addr);
    assign rx_hold = ~ctrl_q.rx_en | ovr_q;
    assign stat_wr = reg_wr & (addr == RA_STAT);
    assign stat_rd = reg_rd & (addr == RA_STAT);
    assign pop     = reg_rd & (addr == RA_DATA);

    srx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .clk_rise (clk_rise),
        .dat_sync (dat_sync)
    );

    srx_shifter #(.BITS(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (clk_rise),
        .bit_in    (dat_sync),
        .hold      (rx_hold),
        .byte_done (byte_done),
        .byte_out  (byte_val)
    );

    srx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (byte_done),
        .wdata      (byte_val),
        .pop        (pop),
        .head       (head),
        .empty      (fifo_empty),
        .overflow   (fifo_ovf),
        .count      (fifo_count),
        .count_next (cnt_next)
    );

    // Map the trigger select field to a byte count.
    always_comb begin
        case (ctrl_q.trig_sel)
            2'd0:    trig_lvl = CNT_W'(TRIG_L0);
            2'd1:    trig_lvl = CNT_W'(TRIG_L1);
            2'd2:    trig_lvl = CNT_W'(TRIG_L2);
            default: trig_lvl = CNT_W'(TRIG_L3);
        endcase
    end

    // Clear sources: the software handshake and reads from a DMA engine.
    assign sw_clr  = stat_wr & ~reg_wdata[ST_RDY] & armed_q;
    assign dma_clr = ctrl_q.dma_sel & reg_rd & ((addr == RA_DATA) || (addr == RA_COUNT));

    // Ready flag: the level condition wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= (cnt_next >= trig_lvl) | (rdy_q & ~(sw_clr | dma_clr));
    end

    // Handshake arm: a status read that sees the flag set arms one clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (stat_wr) armed_q <= 1'b0;
        else if (stat_rd) armed_q <= rdy_q;
    end

    // Overrun flag: set by a refused push, cleared by writing its bit as 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ovr_q <= 1'b0;
        else if (fifo_ovf)                      ovr_q <= 1'b1;
        else if (stat_wr && !reg_wdata[ST_OVR]) ovr_q <= 1'b0;
    end

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_q <= '0;
        else if (reg_wr && addr == RA_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // Last popped byte, returned again by reads of an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_q <= '0;
        else if (pop && !fifo_empty) last_q <= head;
    end

    // Registered read mux, loaded on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            rdata_q <= '0;
            case (addr)
                RA_DATA:  rdata_q <= fifo_empty ? last_q : head;
                RA_STAT: begin
                    rdata_q[ST_RDY] <= rdy_q;
                    rdata_q[ST_OVR] <= ovr_q;
                end
                RA_COUNT: rdata_q[CNT_W-1:0]  <= fifo_count;
                default:  rdata_q[CTRL_W-1:0] <= ctrl_q;
            endcase
        end
    end

    assign reg_rdata = rdata_q;
    assign irq_o     = rdy_q & ~ctrl_q.dma_sel;
    assign dma_req_o = rdy_q &  ctrl_q.dma_sel;

endmodule

// File: rtl/srx_checker.sv
// Timing properties of the serial receive block, bound to its internals.
module srx_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] trig_lvl,
    input logic             rdy,
    input logic             ovr,
    input logic             rx_en,
    input logic             dma_sel,
    input logic             irq_o,
    input logic             dma_req_o
);

    p_count_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_rdy_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= trig_lvl && $stable(trig_lvl)) |-> rdy);

    p_rdy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> (($past(reg_wr) && $past(reg_addr) == 2'd1) ||
                        ($past(reg_rd) && $past(dma_sel))));

    p_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && dma_req_o));

    p_ovr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(count) == CNT_W'(DEPTH));

    p_ovr_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> count <= $past(count));

    p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> count <= $past(count));

endmodule

bind sync_serial_rx_fifo srx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .count     (fifo_count),
    .trig_lvl  (trig_lvl),
    .rdy       (rdy_q),
    .ovr       (ovr_q),
    .rx_en     (ctrl_q.rx_en),
    .dma_sel   (ctrl_q.dma_sel),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
);

// File: tb/tb_sync_serial_rx_fifo.sv
module tb_sync_serial_rx_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o;
    logic       dma_req_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] model_q[$];
    logic [7:0] last_pop = 8'h00;
    logic [7:0] rv;

    always #4 clk = ~clk;

    sync_serial_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int trig_of(input logic [1:0] sel);
        case (sel)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_clk = 1'b0; ser_dat = b[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Pop one byte and compare against the model.
    task automatic pop_check(input string req);
        logic [7:0] exp;
        exp = model_q.pop_front();
        last_pop = exp;
        reg_read(2'd0, rv);
        check(req, rv, exp);
    endtask

    task automatic clear_rdy();
        reg_read(2'd1, rv);
        reg_write(2'd1, 8'h00);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 irq", irq_o, 0);
        check("R11 dma_req", dma_req_o, 0);
        reg_read(2'd1, rv); check("R11 status", rv, 8'h00);
        reg_read(2'd2, rv); check("R11 count", rv, 8'h00);
        reg_read(2'd3, rv); check("R11 control", rv, 8'h00);

        // R1/R2/R3/R5: single byte with trigger 1
        reg_write(2'd3, 8'h01);
        send_bits(8'hA5, 8); model_q.push_back(8'hA5);
        reg_read(2'd2, rv); check("R2 count one", rv, 1);
        check("R3/R5 irq at trigger 1", irq_o, 1);
        check("R5 dma_req off", dma_req_o, 0);
        pop_check("R1 lsb first");
        reg_read(2'd2, rv); check("R2 count after pop", rv, 0);
        check("R3 flag sticky below trigger", irq_o, 1);

        // R4: write of 0 without a prior status read is ignored
        reg_write(2'd1, 8'h02);
        check("R4 unarmed clear ignored", irq_o, 1);
        reg_read(2'd1, rv); check("R4 status read", rv, 8'h01);
        reg_write(2'd1, 8'h03);
        check("R4 write one keeps flag", irq_o, 1);
        reg_read(2'd1, rv);
        reg_write(2'd1, 8'h02);
        check("R4 armed clear", irq_o, 0);
        reg_read(2'd1, rv); check("R4 status cleared", rv, 8'h00);

        // R10: empty read returns last popped byte
        reg_read(2'd0, rv); check("R10 empty data", rv, 8'hA5);
        reg_read(2'd2, rv); check("R10 empty count", rv, 0);

        // R3: trigger 4 boundary
        reg_write(2'd3, 8'h03);
        for (int i = 0; i < 3; i++) begin
            send_bits(8'h10 + 8'(i), 8); model_q.push_back(8'h10 + 8'(i));
        end
        check("R3 below trigger 4", irq_o, 0);
        send_bits(8'h3C, 8); model_q.push_back(8'h3C);
        check("R3 at trigger 4", irq_o, 1);
        while (model_q.size() > 0) pop_check("R1 order");
        clear_rdy();

        // Random rounds: bursts and drains with random trigger
        for (int r = 0; r < 8; r++) begin
            logic [1:0] sel;
            int n, m;
            sel = 2'($urandom_range(0, 3));
            reg_write(2'd3, {5'b0, sel, 1'b1});
            n = $urandom_range(1, 16 - model_q.size());
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'($urandom);
                send_bits(b, 8); model_q.push_back(b);
            end
            reg_read(2'd2, rv); check("R2 random count", rv, model_q.size());
            if (model_q.size() >= trig_of(sel)) check("R3 random trigger", irq_o, 1);
            m = $urandom_range(0, model_q.size());
            for (int i = 0; i < m; i++) pop_check("R1 random data");
        end
        while (model_q.size() > 0) pop_check("R1 drain");
        reg_write(2'd3, 8'h01);
        clear_rdy();
        check("R4 cleared after drain", irq_o, 0);

        // R5/R6: DMA routing with trigger 4
        reg_write(2'd3, 8'h0B);
        for (int i = 0; i < 4; i++) begin
            send_bits(8'hC0 + 8'(i), 8); model_q.push_back(8'hC0 + 8'(i));
        end
        check("R5 dma_req raised", dma_req_o, 1);
        check("R5 irq masked", irq_o, 0);
        pop_check("R6 dma data");
        check("R6 dma read clears", dma_req_o, 0);
        reg_read(2'd1, rv); check("R6 status after dma read", rv, 8'h00);
        send_bits(8'hC4, 8); model_q.push_back(8'hC4);
        check("R6 dma_req again", dma_req_o, 1);
        reg_read(2'd2, rv); check("R6 count read keeps at level", dma_req_o, 1);
        pop_check("R6 dma data 2");
        reg_read(2'd2, rv); check("R6 count read clears", dma_req_o, 0);
        check("R6 count value", rv, 3);
        while (model_q.size() > 0) pop_check("R1 dma drain");
        reg_write(2'd3, 8'h01);
        clear_rdy();

        // R7/R8: overrun
        for (int i = 0; i < 16; i++) begin
            send_bits(8'(i * 7 + 3), 8); model_q.push_back(8'(i * 7 + 3));
        end
        send_bits(8'hFF, 8);
        reg_read(2'd2, rv); check("R7 count stays full", rv, 16);
        reg_read(2'd1, rv); check("R7 overrun flag", rv[1], 1);
        pop_check("R7 head kept");
        send_bits(8'hEE, 8);
        reg_read(2'd2, rv); check("R8 ignored while locked", rv, 15);
        reg_write(2'd1, 8'h01);
        reg_read(2'd1, rv); check("R8 overrun cleared", rv[1], 0);
        send_bits(8'h5C, 8); model_q.push_back(8'h5C);
        reg_read(2'd2, rv); check("R8 resumed", rv, 16);
        while (model_q.size() > 0) pop_check("R7 data after overrun");
        clear_rdy();

        // R9: disable mid-byte drops partial bits
        send_bits(8'hFF, 4);
        reg_write(2'd3, 8'h00);
        send_bits(8'h33, 8);
        reg_read(2'd2, rv); check("R9 disabled ignored", rv, 0);
        reg_write(2'd3, 8'h01);
        send_bits(8'h96, 8); model_q.push_back(8'h96);
        reg_read(2'd2, rv); check("R9 count after re-enable", rv, 1);
        pop_check("R9 clean byte");
        reg_read(2'd0, rv); check("R10 repeat last", rv, last_pop);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule